// File: doc/BRIEF.md
# Windowed Register File with Call/Return Rotation

This block is a register file for code that uses a register window per procedure. A 5-bit logical register number is combined with a current-window pointer to select one physical register. Logical numbers 0 to 7 reach a shared set of global registers. Numbers 8 to 31 reach the 24 registers of the active window. A call strobe moves the pointer one window forward. A return strobe moves it one window back.

Adjacent windows share registers. The output registers of a procedure are therefore the input registers of the procedure it calls, and arguments and results pass between them without any copy.

The file holds a ring of `NWIN` windows, which must be between 2 and 32. A saved-window pointer marks the oldest window still held in the file. The block does not save windows to memory. Instead it pulses an overflow flag when a call would land on the saved window, and an underflow flag when a return is attempted from the saved window. In both cases the pointer stays where it is, and a spill or fill engine outside the block can act.

Top module: `regwin_file`

## Requirements
- R1: Logical registers 0 to 7 select the same physical register whatever the current window, so a value written to one of them in one window reads back unchanged in any other window.
- R2: Logical registers 16 to 23 are private to their window. A write to one of them in window w+1 leaves the same logical register of window w unchanged.
- R3: After a call, logical register 24+k (k from 0 to 7) reads the value that the caller held in logical register 8+k. After a return, logical register 8+k of the caller reads what the callee held in 24+k.
- R4: Both read ports are combinational and independent. Each one returns the current contents of its own addressed register in the same cycle, including when both ports name the same register.
- R5: A write takes effect at the rising clock edge. A read port addressing the register being written in that cycle returns the write data before the edge.
- R6: A call whose next window equals the saved window sets `win_ovf` high for exactly the one cycle after the edge and leaves the current window unchanged. From reset, NWIN-1 calls succeed and the NWIN-th call overflows.
- R7: A return while the current window equals the saved window sets `win_unf` high for exactly one cycle and leaves the current window unchanged. Immediately after reset, a return underflows.
- R8: A synchronous, active-high `rst` clears both window pointers to window 0 and clears both flags.
- R9: A cycle with both `call_req` and `ret_req` high is ignored. The window does not move and no flag is raised.
- R10: The ring wraps around. The output registers (8 to 15) of window NWIN-1 are physically the input registers (24 to 31) of window 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rs_a | input | 5 | Logical register number for read port A |
| rdata_a | output | DW | Read data A (combinational) |
| rs_b | input | 5 | Logical register number for read port B |
| rdata_b | output | DW | Read data B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 5 | Logical register number to write |
| wr_data | input | DW | Write data |
| call_req | input | 1 | Advance to the next window |
| ret_req | input | 1 | Go back to the previous window |
| win_ovf | output | 1 | One-cycle pulse: a call was refused because the file is full |
| win_unf | output | 1 | One-cycle pulse: a return was refused because the file is empty |

## Verification
The bench walks the pointer all the way around the ring. A design that let the pointer step onto the saved window would accept an NWIN-th call with no overflow, and the local registers of window NWIN-1 would then read another window's contents. On the way back, the bench checks that a value left in an output register of the last window turns up as an input register of window 0; a modulo error in the mapping returns a stale or undefined value there. The other cases covered are:
- an output/input mapping in the wrong direction, which shows up as a missing argument after a call;
- a missing write bypass, which shows old data before the edge;
- a call and a return in the same cycle, which a careless design would act on.

// File: rtl/regwin_file.sv
module regwin_file #(
  parameter int NWIN = 8,
  parameter int DW   = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [4:0]    rs_a,
  output logic [DW-1:0] rdata_a,
  input  logic [4:0]    rs_b,
  output logic [DW-1:0] rdata_b,
  input  logic          wr_en,
  input  logic [4:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          call_req,
  input  logic          ret_req,
  output logic          win_ovf,
  output logic          win_unf
);
  localparam int WB    = (NWIN > 2) ? $clog2(NWIN) : 1;
  localparam int RING  = NWIN * 16;
  localparam int NPHYS = 8 + RING;
  localparam int PW    = $clog2(NPHYS);
  localparam logic [WB-1:0] LASTW = WB'(NWIN - 1);

  logic [DW-1:0] rf [NPHYS];
  logic [WB-1:0] cwp, swp, cwp_up, cwp_dn;
  logic          do_call, do_ret, ovf_hit, unf_hit;

  // Window offsets: inputs 0..7, locals 8..15, outputs 16..23.
  // The outputs of window w then coincide with the inputs of window w+1.
  function automatic logic [PW-1:0] phys(input logic [4:0] r, input logic [WB-1:0] w);
    int off;
    if (r < 5'd8) return PW'(r);
    if (r >= 5'd24)      off = int'(r) - 24;
    else if (r >= 5'd16) off = int'(r) - 8;
    else                 off = int'(r) + 8;
    return PW'(8 + ((int'(w) * 16 + off) % RING));
  endfunction

  assign cwp_up  = (cwp == LASTW) ? '0 : cwp + 1'b1;
  assign cwp_dn  = (cwp == '0) ? LASTW : cwp - 1'b1;
  assign do_call = call_req & ~ret_req;
  assign do_ret  = ret_req & ~call_req;
  assign ovf_hit = do_call & (cwp_up == swp);
  assign unf_hit = do_ret & (cwp == swp);

  always_ff @(posedge clk) begin
    if (rst) begin
      cwp     <= '0;
      swp     <= '0;
      win_ovf <= 1'b0;
      win_unf <= 1'b0;
    end else begin
      win_ovf <= ovf_hit;
      win_unf <= unf_hit;
      if (do_call && !ovf_hit)     cwp <= cwp_up;
      else if (do_ret && !unf_hit) cwp <= cwp_dn;
    end
  end

  always_ff @(posedge clk)
    if (wr_en) rf[phys(wr_sel, cwp)] <= wr_data;

  assign rdata_a = (wr_en && wr_sel == rs_a) ? wr_data : rf[phys(rs_a, cwp)];
  assign rdata_b = (wr_en && wr_sel == rs_b) ? wr_data : rf[phys(rs_b, cwp)];
endmodule

// File: rtl/regwin_file_chk.sv
module regwin_file_chk #(
  parameter int NWIN = 8,
  parameter int DW   = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [4:0]    rs_a,
  input logic [DW-1:0] rdata_a,
  input logic          wr_en,
  input logic [4:0]    wr_sel,
  input logic [DW-1:0] wr_data,
  input logic          call_req,
  input logic          ret_req,
  input logic          win_ovf,
  input logic          win_unf,
  input logic [((NWIN > 2) ? $clog2(NWIN) : 1)-1:0] cwp
);
  assert_ovf_cause_R6: assert property (@(posedge clk) disable iff (rst)
    win_ovf |-> $past(call_req && !ret_req));
  assert_ovf_hold_R6: assert property (@(posedge clk) disable iff (rst)
    win_ovf |-> cwp == $past(cwp));
  assert_unf_cause_R7: assert property (@(posedge clk) disable iff (rst)
    win_unf |-> $past(ret_req && !call_req));
  assert_unf_hold_R7: assert property (@(posedge clk) disable iff (rst)
    win_unf |-> cwp == $past(cwp));
  assert_both_idle_R9: assert property (@(posedge clk) disable iff (rst)
    $past(call_req && ret_req) |-> (!win_ovf && !win_unf && cwp == $past(cwp)));
  assert_bypass_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == rs_a) |-> rdata_a == wr_data);
  assert_reset_state_R8: assert property (@(posedge clk)
    $past(rst) |-> (!win_ovf && !win_unf && cwp == '0));
endmodule

bind regwin_file regwin_file_chk #(.NWIN(NWIN), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .rs_a(rs_a), .rdata_a(rdata_a), .wr_en(wr_en),
  .wr_sel(wr_sel), .wr_data(wr_data), .call_req(call_req), .ret_req(ret_req),
  .win_ovf(win_ovf), .win_unf(win_unf), .cwp(cwp)
);

// File: tb/tb_regwin_file.sv
`timescale 1ns/1ps
module tb_regwin_file;
  localparam int NWIN = 8;
  localparam int DW   = 32;

  logic clk = 0, rst = 1;
  logic [4:0] rs_a = 0, rs_b = 0, wr_sel = 0;
  logic [DW-1:0] rdata_a, rdata_b, wr_data = 0;
  logic wr_en = 0, call_req = 0, ret_req = 0;
  logic win_ovf, win_unf;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  regwin_file #(.NWIN(NWIN), .DW(DW)) dut (
    .clk(clk), .rst(rst), .rs_a(rs_a), .rdata_a(rdata_a), .rs_b(rs_b), .rdata_b(rdata_b),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .call_req(call_req),
    .ret_req(ret_req), .win_ovf(win_ovf), .win_unf(win_unf)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] r, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1; wr_sel = r; wr_data = d;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic rd(input string req, input logic [4:0] r, input logic [DW-1:0] exp);
    @(negedge clk); rs_a = r; #1 chk(req, rdata_a, exp);
  endtask

  task automatic step(input logic c, input logic r, input logic eo, input logic eu, input string req);
    @(negedge clk); call_req = c; ret_req = r;
    @(posedge clk); #1 call_req = 0; ret_req = 0;
    chk({req, " ovf"}, DW'(win_ovf), DW'(eo));
    chk({req, " unf"}, DW'(win_unf), DW'(eu));
  endtask

  task automatic t_reset();
    rst = 1; repeat (2) @(posedge clk); #1;
    chk("R8 ovf", DW'(win_ovf), 0);
    chk("R8 unf", DW'(win_unf), 0);
    @(negedge clk); rst = 0;
    step(0, 1, 0, 1, "R7 return at reset");
    @(posedge clk); #1 chk("R7 pulse one cycle", DW'(win_unf), 0);
  endtask

  task automatic t_globals();
    wr(5'd3, 32'h0000_00A5);
    step(1, 0, 0, 0, "R1 call");
    rd("R1 global seen in window 1", 5'd3, 32'h0000_00A5);
    wr(5'd3, 32'h0000_005A);
    step(0, 1, 0, 0, "R1 return");
    rd("R1 global seen back in window 0", 5'd3, 32'h0000_005A);
  endtask

  task automatic t_locals();
    wr(5'd16, 32'd111);
    step(1, 0, 0, 0, "R2 call");
    wr(5'd16, 32'd222);
    rd("R2 callee local", 5'd16, 32'd222);
    step(0, 1, 0, 0, "R2 return");
    rd("R2 caller local kept", 5'd16, 32'd111);
  endtask

  task automatic t_overlap();
    wr(5'd9, 32'h99);
    step(1, 0, 0, 0, "R3 call");
    rd("R3 out->in after call", 5'd25, 32'h99);
    wr(5'd26, 32'h77);
    step(0, 1, 0, 0, "R3 return");
    rd("R3 in->out after return", 5'd10, 32'h77);
  endtask

  task automatic t_dual();
    @(negedge clk); rs_a = 5'd16; rs_b = 5'd9; #1;
    chk("R4 port A", rdata_a, 32'd111);
    chk("R4 port B", rdata_b, 32'h99);
    rs_b = 5'd16; #1 chk("R4 both same", rdata_b, 32'd111);
  endtask

  task automatic t_bypass();
    @(negedge clk); wr_en = 1; wr_sel = 5'd20; wr_data = 32'hBEEF; rs_a = 5'd20; rs_b = 5'd20; #1;
    chk("R5 bypass A", rdata_a, 32'hBEEF);
    chk("R5 bypass B", rdata_b, 32'hBEEF);
    @(posedge clk); #1 wr_en = 0;
    rd("R5 stored", 5'd20, 32'hBEEF);
  endtask

  task automatic t_ring();
    for (int i = 0; i < NWIN - 1; i++) step(1, 0, 0, 0, "R6 call in range");
    wr(5'd17, 32'h7777);
    wr(5'd8, 32'hC0DE);
    step(1, 0, 1, 0, "R6 overflow call");
    @(posedge clk); #1 chk("R6 pulse one cycle", DW'(win_ovf), 0);
    rd("R6 window unchanged", 5'd17, 32'h7777);
    for (int i = 0; i < NWIN - 1; i++) step(0, 1, 0, 0, "R10 return");
    rd("R10 wrap out->in", 5'd24, 32'hC0DE);
    rd("R10 back in window 0", 5'd16, 32'd111);
    step(0, 1, 0, 1, "R7 underflow");
    rd("R7 window unchanged", 5'd16, 32'd111);
  endtask

  task automatic t_both();
    step(1, 1, 0, 0, "R9 simultaneous");
    rd("R9 window unchanged", 5'd16, 32'd111);
  endtask

  initial begin
    t_reset();
    t_globals();
    t_locals();
    t_overlap();
    t_dual();
    t_bypass();
    t_ring();
    t_both();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule